// File: doc/BRIEF.md
# Two-Level PLL Power Sequencer

This block powers a shared reference PLL on and off without software. Two downstream PLLs take their clock from it. Each downstream PLL has a sequencer of its own, and each of those sequencers watches a group of consumer ports. A downstream sequencer shuts its PLL off only when every one of its ports reports low power. When it is fully off and nothing needs it, it raises an idle flag.

The root sequencer watches the two idle flags. It powers the reference PLL down when both flags are high, and back up when either flag clears. The root brings the reference PLL up first, through a power-up step and a lock wait. Only then does it assert ready, and only then may the downstream sequencers power their own PLLs. The analog PLLs are outside the block; they are modelled by a power output and a lock input each.

A strobe, `arm_req`, hands the root to hardware. It is a control pin, not a stream, and it is sampled only while `arm_busy` is low. An arm request is refused when the reference PLL is unlocked, or when the two downstream sequencers are not both enabled. An accepted request writes the setup fields, waits one settling interval, sets the sequencer-enable bit, and waits a second interval before it reports completion.

Top module: `pll_pwr_seq_top`

## Requirements
- R1: In reset: `ctrl_reg` is 0; `aux_reg` is 0x0000_0050 (bits 4 and 6 set); all three state outputs are 0; `ref_pwr` and `arm_busy` are low.
- R2: If aux bit 24 is already set, an arm request gives `arm_done` one cycle later with `arm_status` 0, and both registers stay unchanged.
- R3: If aux bit 24 is clear and `ref_lock` is low, an arm request gives `arm_done` one cycle later with `arm_status` 1 and changes nothing. This check takes priority over R4.
- R4: If aux bit 24 is clear, the PLL is locked, and `ds_en_a` and `ds_en_b` are not both high, an arm request gives `arm_done` one cycle later with `arm_status` 2, and `aux_reg` is unchanged.
- R5: An accepted arm request acts on the edge that samples it. It clears `ctrl_reg` bit 14, sets aux bits 3 and 31, and clears aux bits 4 and 6. Aux bit 24 is set SETTLE_CYC edges later. `arm_done` with status 0 comes SETTLE_CYC edges after that. `arm_busy` is high in between, and `arm_req` is ignored while busy.
- R6: Each sequencer steps OFF, then PWRUP for one cycle, then WLOCK. The root leaves WLOCK on `ref_lock` once aux bit 3 is set; before that it leaves WLOCK after one cycle. `ref_ready` is high only in ON.
- R7: While aux bit 24 is clear, the root keeps the reference PLL wanted unless `ctrl_reg` bit 14 is set. Once bit 24 is set, the root powers down when both idle flags are high, and powers back up when either flag clears.
- R8: A downstream sequencer leaves ON only if its enable is high and all its `ports_lp` bits are high, or if root ready is lost. Its idle flag is high only when it is OFF and not wanted.
- R9: A downstream PLL power output rises only after a cycle in which `ref_ready` was high.
- R10: The state encoding is OFF=0, PWRUP=1, WLOCK=2, ON=3, PWRDN=4. A power output is high in states 1 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_req | input | 1 | Strobe requesting hardware control of the root |
| arm_busy | output | 1 | Arm sequence in progress |
| arm_done | output | 1 | One-cycle completion pulse |
| arm_status | output | 2 | 0 ok, 1 not locked, 2 order refused |
| ds_en_a | input | 1 | Downstream sequencer A enabled |
| ds_en_b | input | 1 | Downstream sequencer B enabled |
| ports_lp_a | input | PORTS_A | Low-power flags of A's consumers |
| ports_lp_b | input | PORTS_B | Low-power flags of B's consumers |
| ref_lock | input | 1 | Reference PLL lock |
| ref_pwr | output | 1 | Reference PLL power |
| ref_ready | output | 1 | Reference PLL up and usable |
| pll_lock_a | input | 1 | Downstream PLL A lock |
| pll_lock_b | input | 1 | Downstream PLL B lock |
| pll_pwr_a | output | 1 | Downstream PLL A power |
| pll_pwr_b | output | 1 | Downstream PLL B power |
| idle_a | output | 1 | Sequencer A idle flag |
| idle_b | output | 1 | Sequencer B idle flag |
| ctrl_reg | output | 32 | Control register (bit 14 software power-down) |
| aux_reg | output | 32 | Auxiliary register (bits 3, 4, 6, 24, 31) |
| root_state | output | 3 | Root sequencer state |
| leaf_state_a | output | 3 | Sequencer A state |
| leaf_state_b | output | 3 | Sequencer B state |

## Verification
On every cycle, the assertions check these rules:
- A downstream PLL never powers before root ready.
- A downstream PLL drops only for its own ports or for lost readiness.
- With lock detect in use, the root reaches ON only after lock.
- The root leaves ON once both flags are idle.
- Sequencer enable rises only with the setup fields in place and both downstream enables high.
- The immediate arm outcomes follow their rules.

Other behaviour needs the bench's scenarios:
- the exact settling counts;
- the refusal priority;
- dropped strobes while busy;
- the full two-level power-down and wake order across many cycles.

// File: rtl/pps_pkg.sv
`timescale 1ns/1ps
package pps_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_PWRUP = 3'd1,
    ST_WLOCK = 3'd2,
    ST_ON    = 3'd3,
    ST_PWRDN = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    ARM_OK     = 2'd0,
    ARM_NOLOCK = 2'd1,
    ARM_ORDER  = 2'd2
  } arm_status_e;

  localparam int unsigned BIT_PDN_SW  = 14;
  localparam int unsigned BIT_LOCKDET = 3;
  localparam int unsigned BIT_EN_SW   = 4;
  localparam int unsigned BIT_SS_SW   = 6;
  localparam int unsigned BIT_SEQ_EN  = 24;
  localparam int unsigned BIT_SS_INC  = 31;
endpackage

// File: rtl/pps_fsm.sv
`timescale 1ns/1ps
module pps_fsm
  import pps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       want_on,
  input  logic       permit,
  input  logic       lock_ok,
  output seq_state_e state,
  output logic       pwr
);
  seq_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_OFF:   if (want_on && permit) nxt = ST_PWRUP;
      ST_PWRUP: nxt = permit ? ST_WLOCK : ST_PWRDN;
      ST_WLOCK: if (!permit) nxt = ST_PWRDN;
                else if (lock_ok) nxt = ST_ON;
      ST_ON:    if (!want_on || !permit) nxt = ST_PWRDN;
      ST_PWRDN: nxt = ST_OFF;
      default:  nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= nxt;
  end

  assign pwr = (state == ST_PWRUP) || (state == ST_WLOCK) || (state == ST_ON);

  // R6: power-up lasts one cycle before the lock wait or an abort
  p_pwrup_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_PWRUP |=> (state == ST_WLOCK || state == ST_PWRDN));
endmodule

// File: rtl/pps_root.sv
`timescale 1ns/1ps
module pps_root
  import pps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle_a,
  input  logic       idle_b,
  input  logic       seq_en,
  input  logic       pdn_sw,
  input  logic       use_lock,
  input  logic       ref_lock,
  output seq_state_e state,
  output logic       ref_pwr,
  output logic       ref_ready
);
  logic want_on;
  logic lock_ok;

  assign want_on = seq_en ? !(idle_a && idle_b) : !pdn_sw;
  assign lock_ok = !use_lock || ref_lock;

  pps_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .want_on (want_on),
    .permit  (1'b1),
    .lock_ok (lock_ok),
    .state   (state),
    .pwr     (ref_pwr)
  );

  assign ref_ready = (state == ST_ON);

  // R6: with lock detect in use, ready only follows a locked cycle
  p_ready_after_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ref_ready) && $past(use_lock)) |-> $past(ref_lock));

  // R7: both downstream idle under hardware control drops the root
  p_root_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_en && ref_ready && idle_a && idle_b) |=> !ref_ready);
endmodule

// File: rtl/pps_leaf.sv
`timescale 1ns/1ps
module pps_leaf
  import pps_pkg::*;
#(
  parameter int unsigned N_PORTS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hw_en,
  input  logic [N_PORTS-1:0] port_lp,
  input  logic               root_ready,
  input  logic               pll_lock,
  output seq_state_e         state,
  output logic               pll_pwr,
  output logic               idle
);
  logic all_lp;
  logic want_on;

  assign all_lp  = &port_lp;
  assign want_on = !(hw_en && all_lp);

  pps_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .want_on (want_on),
    .permit  (root_ready),
    .lock_ok (pll_lock),
    .state   (state),
    .pwr     (pll_pwr)
  );

  assign idle = (state == ST_OFF) && !want_on;

  // R9: a downstream PLL powers only once the reference is ready
  p_wait_root_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_pwr) |-> $past(root_ready));

  // R8: power drops only for all-idle consumers or lost readiness
  p_drop_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_pwr) |-> ($past(hw_en && all_lp) || !$past(root_ready)));
endmodule

// File: rtl/pps_arm.sv
`timescale 1ns/1ps
module pps_arm
  import pps_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        arm_req,
  input  logic        ref_lock,
  input  logic        ds_en_a,
  input  logic        ds_en_b,
  output logic        arm_busy,
  output logic        arm_done,
  output arm_status_e arm_status,
  output logic        pdn_sw,
  output logic        use_lock,
  output logic        seq_en,
  output logic [31:0] ctrl_reg,
  output logic [31:0] aux_reg
);
  localparam int unsigned CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC - 1);

  typedef enum logic [1:0] {A_IDLE, A_SET1, A_SET2} arm_st_e;
  arm_st_e       st;
  logic [CW-1:0] cnt;
  logic          ss_inc, en_sw, ss_sw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= A_IDLE;
      cnt        <= '0;
      pdn_sw     <= 1'b0;
      use_lock   <= 1'b0;
      ss_inc     <= 1'b0;
      en_sw      <= 1'b1;
      ss_sw      <= 1'b1;
      seq_en     <= 1'b0;
      arm_done   <= 1'b0;
      arm_status <= ARM_OK;
    end else begin
      arm_done <= 1'b0;
      case (st)
        A_IDLE: if (arm_req) begin
          if (seq_en) begin
            arm_done <= 1'b1; arm_status <= ARM_OK;
          end else if (!ref_lock) begin
            arm_done <= 1'b1; arm_status <= ARM_NOLOCK;
          end else if (!(ds_en_a && ds_en_b)) begin
            arm_done <= 1'b1; arm_status <= ARM_ORDER;
          end else begin
            pdn_sw   <= 1'b0;
            use_lock <= 1'b1;
            ss_inc   <= 1'b1;
            en_sw    <= 1'b0;
            ss_sw    <= 1'b0;
            cnt      <= LOAD;
            st       <= A_SET1;
          end
        end
        A_SET1: if (cnt == '0) begin
          seq_en <= 1'b1;
          cnt    <= LOAD;
          st     <= A_SET2;
        end else cnt <= cnt - 1'b1;
        A_SET2: if (cnt == '0) begin
          arm_done   <= 1'b1;
          arm_status <= ARM_OK;
          st         <= A_IDLE;
        end else cnt <= cnt - 1'b1;
        default: st <= A_IDLE;
      endcase
    end
  end

  assign arm_busy = (st != A_IDLE);

  always_comb begin
    ctrl_reg = '0;
    ctrl_reg[BIT_PDN_SW] = pdn_sw;
    aux_reg = '0;
    aux_reg[BIT_LOCKDET] = use_lock;
    aux_reg[BIT_EN_SW]   = en_sw;
    aux_reg[BIT_SS_SW]   = ss_sw;
    aux_reg[BIT_SEQ_EN]  = seq_en;
    aux_reg[BIT_SS_INC]  = ss_inc;
  end

  // R2: already enabled completes at once and leaves the fields alone
  p_already_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_req && !arm_busy && seq_en) |=>
      (arm_done && arm_status == ARM_OK && $stable(aux_reg)));

  // R3: unlocked reference refuses the request
  p_refuse_nolock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_req && !arm_busy && !seq_en && !ref_lock) |=>
      (arm_done && arm_status == ARM_NOLOCK && !arm_busy));

  // R4: enable never rises ahead of both downstream sequencers
  p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_en) |-> (ds_en_a && ds_en_b));

  // R5: enable rises only over a completed setup write
  p_setup_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_en) |-> (use_lock && ss_inc && !en_sw && !ss_sw && !pdn_sw));
endmodule

// File: rtl/pll_pwr_seq_top.sv
`timescale 1ns/1ps
module pll_pwr_seq_top
  import pps_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 200,
  parameter int unsigned SETTLE_NS = 1000,
  parameter int unsigned PORTS_A   = 4,
  parameter int unsigned PORTS_B   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm_req,
  output logic               arm_busy,
  output logic               arm_done,
  output logic [1:0]         arm_status,
  input  logic               ds_en_a,
  input  logic               ds_en_b,
  input  logic [PORTS_A-1:0] ports_lp_a,
  input  logic [PORTS_B-1:0] ports_lp_b,
  input  logic               ref_lock,
  output logic               ref_pwr,
  output logic               ref_ready,
  input  logic               pll_lock_a,
  input  logic               pll_lock_b,
  output logic               pll_pwr_a,
  output logic               pll_pwr_b,
  output logic               idle_a,
  output logic               idle_b,
  output logic [31:0]        ctrl_reg,
  output logic [31:0]        aux_reg,
  output logic [2:0]         root_state,
  output logic [2:0]         leaf_state_a,
  output logic [2:0]         leaf_state_b
);
  localparam int unsigned SETTLE_RAW = (CLK_MHZ * SETTLE_NS + 999) / 1000;
  localparam int unsigned SETTLE_CYC = (SETTLE_RAW == 0) ? 1 : SETTLE_RAW;

  arm_status_e status;
  seq_state_e  st_root, st_a, st_b;
  logic        pdn_sw, use_lock, seq_en;

  pps_arm #(.SETTLE_CYC(SETTLE_CYC)) u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_req    (arm_req),
    .ref_lock   (ref_lock),
    .ds_en_a    (ds_en_a),
    .ds_en_b    (ds_en_b),
    .arm_busy   (arm_busy),
    .arm_done   (arm_done),
    .arm_status (status),
    .pdn_sw     (pdn_sw),
    .use_lock   (use_lock),
    .seq_en     (seq_en),
    .ctrl_reg   (ctrl_reg),
    .aux_reg    (aux_reg)
  );

  pps_root u_root (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle_a    (idle_a),
    .idle_b    (idle_b),
    .seq_en    (seq_en),
    .pdn_sw    (pdn_sw),
    .use_lock  (use_lock),
    .ref_lock  (ref_lock),
    .state     (st_root),
    .ref_pwr   (ref_pwr),
    .ref_ready (ref_ready)
  );

  pps_leaf #(.N_PORTS(PORTS_A)) u_leaf_a (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_en      (ds_en_a),
    .port_lp    (ports_lp_a),
    .root_ready (ref_ready),
    .pll_lock   (pll_lock_a),
    .state      (st_a),
    .pll_pwr    (pll_pwr_a),
    .idle       (idle_a)
  );

  pps_leaf #(.N_PORTS(PORTS_B)) u_leaf_b (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_en      (ds_en_b),
    .port_lp    (ports_lp_b),
    .root_ready (ref_ready),
    .pll_lock   (pll_lock_b),
    .state      (st_b),
    .pll_pwr    (pll_pwr_b),
    .idle       (idle_b)
  );

  assign arm_status   = status;
  assign root_state   = st_root;
  assign leaf_state_a = st_a;
  assign leaf_state_b = st_b;
endmodule

// File: tb/sim_pll_pwr_seq_top.sv
`timescale 1ns/1ps
module sim_pll_pwr_seq_top;
  localparam int PA = 4;
  localparam int PB = 2;
  localparam int SETTLE = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_req = 1'b0;
  logic ds_en_a = 1'b0, ds_en_b = 1'b0;
  logic [PA-1:0] ports_lp_a = '0;
  logic [PB-1:0] ports_lp_b = '0;
  logic ref_lock = 1'b0, pll_lock_a = 1'b0, pll_lock_b = 1'b0;
  logic kill = 1'b0;
  logic [1:0] rc = '0, ac = '0, bc = '0;

  logic arm_busy, arm_done, ref_pwr, ref_ready, pll_pwr_a, pll_pwr_b, idle_a, idle_b;
  logic [1:0]  arm_status;
  logic [31:0] ctrl_reg, aux_reg;
  logic [2:0]  root_state, leaf_state_a, leaf_state_b;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  pll_pwr_seq_top #(.CLK_MHZ(200), .SETTLE_NS(1000), .PORTS_A(PA), .PORTS_B(PB)) u0 (
    .clk(clk), .rst_n(rst_n), .arm_req(arm_req), .arm_busy(arm_busy),
    .arm_done(arm_done), .arm_status(arm_status), .ds_en_a(ds_en_a),
    .ds_en_b(ds_en_b), .ports_lp_a(ports_lp_a), .ports_lp_b(ports_lp_b),
    .ref_lock(ref_lock), .ref_pwr(ref_pwr), .ref_ready(ref_ready),
    .pll_lock_a(pll_lock_a), .pll_lock_b(pll_lock_b), .pll_pwr_a(pll_pwr_a),
    .pll_pwr_b(pll_pwr_b), .idle_a(idle_a), .idle_b(idle_b),
    .ctrl_reg(ctrl_reg), .aux_reg(aux_reg), .root_state(root_state),
    .leaf_state_a(leaf_state_a), .leaf_state_b(leaf_state_b)
  );

  // analog PLL models: lock some cycles after power, lost at once when unpowered
  always @(posedge clk) begin
    if (!ref_pwr || kill) begin rc <= '0; ref_lock <= 1'b0; end
    else begin if (rc != 2'd3) rc <= rc + 1'b1; ref_lock <= (rc == 2'd3); end
    if (!pll_pwr_a) begin ac <= '0; pll_lock_a <= 1'b0; end
    else begin if (ac != 2'd3) ac <= ac + 1'b1; pll_lock_a <= (ac == 2'd3); end
    if (!pll_pwr_b) begin bc <= '0; pll_lock_b <= 1'b0; end
    else begin if (bc != 2'd3) bc <= bc + 1'b1; pll_lock_b <= (bc == 2'd3); end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: one strobe, expected outcome pushed to the scoreboard
  task automatic arm(input logic [1:0] exp, input string tag);
    @(negedge clk);
    arm_req = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    arm_req = 1'b0;
  endtask

  // monitor: compare each completion against the oldest expectation
  always @(negedge clk) begin
    if (rst_n && arm_done) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R5 unexpected arm_done actual=1 expected=0");
      end else begin
        automatic logic [1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, "arm_status", {30'd0, arm_status}, {30'd0, e});
      end
    end
  end

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    cyc(3);
    // R1 reset values, R10 encoding of OFF
    chk("R1", "root_state", {29'd0, root_state}, 32'd0);
    chk("R1", "leaf_a", {29'd0, leaf_state_a}, 32'd0);
    chk("R1", "leaf_b", {29'd0, leaf_state_b}, 32'd0);
    chk("R1", "aux_reg", aux_reg, 32'h0000_0050);
    chk("R1", "ctrl_reg", ctrl_reg, 32'd0);
    chk("R1", "ref_pwr", {31'd0, ref_pwr}, 32'd0);
    chk("R1", "arm_busy", {31'd0, arm_busy}, 32'd0);
    rst_n = 1'b1;
    cyc(1);
    chk("R6", "root PWRUP", {29'd0, root_state}, 32'd1);
    chk("R10", "ref_pwr in PWRUP", {31'd0, ref_pwr}, 32'd1);
    cyc(1);
    chk("R6", "root WLOCK", {29'd0, root_state}, 32'd2);
    cyc(1);
    chk("R6", "root ON without lockdet", {29'd0, root_state}, 32'd3);
    chk("R6", "ref_ready", {31'd0, ref_ready}, 32'd1);
    cyc(20);
    chk("R7", "leaf_a ON", {29'd0, leaf_state_a}, 32'd3);
    chk("R7", "leaf_b ON", {29'd0, leaf_state_b}, 32'd3);

    // R8: disabled sequencer ignores all-idle consumers
    ports_lp_a = '1;
    cyc(10);
    chk("R8", "disabled leaf_a stays ON", {29'd0, leaf_state_a}, 32'd3);
    chk("R8", "disabled idle_a", {31'd0, idle_a}, 32'd0);
    ports_lp_a = '0;

    // R4: order refusals
    arm(2'd2, "R4");
    cyc(3);
    chk("R4", "aux unchanged", aux_reg, 32'h0000_0050);
    ds_en_a = 1'b1;
    arm(2'd2, "R4");
    cyc(3);

    // R3: lock refusal, taking priority over order
    ds_en_b = 1'b0;
    kill = 1'b1;
    cyc(3);
    arm(2'd1, "R3");
    cyc(3);
    chk("R3", "ctrl unchanged", ctrl_reg, 32'd0);
    chk("R3", "aux unchanged", aux_reg, 32'h0000_0050);
    ds_en_b = 1'b1;
    kill = 1'b0;
    cyc(10);

    // R5: accepted arm with settling windows
    arm(2'd0, "R5");
    chk("R5", "setup write", aux_reg, 32'h8000_0008);
    chk("R5", "pdn cleared", ctrl_reg, 32'd0);
    chk("R5", "busy", {31'd0, arm_busy}, 32'd1);
    cyc(4);
    arm_req = 1'b1;
    cyc(1);
    arm_req = 1'b0;
    cyc(SETTLE - 1 - 5);
    chk("R5", "enable not yet", aux_reg, 32'h8000_0008);
    cyc(1);
    chk("R5", "enable set", aux_reg, 32'h8100_0008);
    chk("R5", "busy in second wait", {31'd0, arm_busy}, 32'd1);
    cyc(SETTLE + 5);
    chk("R5", "busy cleared", {31'd0, arm_busy}, 32'd0);
    chk("R5", "scoreboard drained", exp_q.size(), 32'd0);

    // R2: already enabled
    arm(2'd0, "R2");
    chk("R2", "aux unchanged", aux_reg, 32'h8100_0008);
    chk("R2", "busy", {31'd0, arm_busy}, 32'd0);
    cyc(3);

    // R8: partial idle keeps the PLL up
    ports_lp_a = '1;
    ports_lp_a[PA-1] = 1'b0;
    cyc(10);
    chk("R8", "partial idle leaf_a ON", {29'd0, leaf_state_a}, 32'd3);
    ports_lp_a = '1;
    cyc(10);
    chk("R8", "leaf_a OFF", {29'd0, leaf_state_a}, 32'd0);
    chk("R8", "idle_a", {31'd0, idle_a}, 32'd1);
    chk("R8", "pll_pwr_a", {31'd0, pll_pwr_a}, 32'd0);
    chk("R7", "root stays ON with one idle", {29'd0, root_state}, 32'd3);

    // R7: both idle powers the root down
    ports_lp_b = '1;
    cyc(15);
    chk("R7", "leaf_b OFF", {29'd0, leaf_state_b}, 32'd0);
    chk("R7", "root OFF", {29'd0, root_state}, 32'd0);
    chk("R7", "ref_pwr off", {31'd0, ref_pwr}, 32'd0);

    // R9: wake-up order, reference first
    @(negedge clk);
    ports_lp_a[0] = 1'b0;
    cyc(1);
    chk("R7", "root PWRUP on wake", {29'd0, root_state}, 32'd1);
    chk("R9", "leaf_a held OFF", {29'd0, leaf_state_a}, 32'd0);
    cyc(2);
    chk("R6", "root waits for lock", {29'd0, root_state}, 32'd2);
    chk("R9", "pll_pwr_a low before ready", {31'd0, pll_pwr_a}, 32'd0);
    cyc(20);
    chk("R6", "root ON after lock", {29'd0, root_state}, 32'd3);
    chk("R9", "leaf_a ON", {29'd0, leaf_state_a}, 32'd3);
    chk("R8", "leaf_b still OFF", {29'd0, leaf_state_b}, 32'd0);
    chk("R8", "idle_b", {31'd0, idle_b}, 32'd1);
    summary();
  end
endmodule